// File: doc/BRIEF.md
# One-Bit Serial Register Access Port

This block lets a host reach a wide control register and a small status register through one data pin. Each chip-select pulse performs one operation. The address and direction strobes, sampled when chip select falls, choose that operation: shift one written bit in, shift one bit out, commit the shifted image to the control register, or load live status into the image for readback. All storage sits behind one 59-stage circulating image. Stages 0..46 hold the control image and stages 47..58 hold the status image.

The host pins are asynchronous to the pixel clock. Every pin passes through a two-flop synchronizer, and chip-select edges are detected in the pixel clock domain, so the committed control word changes on a known pixel clock edge. The data pin has a separate output value and output enable, which an I/O cell outside this block combines into the bidirectional pad. A read starts with a status-load pulse, then returns status bit 58 first and walks down to control bit 0.

Top module: `srp_top`

## Requirements
- R1: While `rstN` is low, `ctrlReg` equals `CTRL_DEFAULT` (all zeros, so software reset bit 0 is low) and `d0Oe` is low.
- R2: `d0Oe` is low in every cycle where `csN` is high. `d0Oe` is high only during the low phase of a read pulse (`a0`=0, `rdWrN`=1 at the chip-select fall).
- R3: A write pulse (`a0`=0, `rdWrN`=0) shifts the `d0In` value present at the chip-select rise into control stage 46. Control stages 46..1 move down by one. After 47 write pulses, the first bit written sits in control bit 0.
- R4: A commit pulse (`a0`=1, `rdWrN`=0) copies control stages 46..0 into `ctrlReg`. The new value appears on the third `clk` rising edge after `csN` rises: two synchronizer stages plus the edge detector.
- R5: `ctrlReg` changes only on a commit pulse. Write pulses, read pulses and status-load pulses leave it unchanged.
- R6: A status-load pulse (`a0`=1, `rdWrN`=1) loads `statusIn` into stages 58..47, with `statusIn[11]` at stage 58. Those stages then keep following `statusIn` on every clock.
- R7: During a read pulse, `d0Out` carries stage 58. At the chip-select rise the whole image rotates one place toward stage 58, and stage 58 wraps into stage 0. The 59 reads after a status-load pulse therefore return the status MSB first, then control bits 46 down to 0.
- R8: After 59 read pulses the image is back in its starting order. Another status-load pulse followed by 59 reads returns the same control bits. A commit issued right after a full read leaves `ctrlReg` unchanged.
- R9: Only the `a0` and `rdWrN` values present at the chip-select fall select the operation. Changing them while `csN` is low has no effect on that pulse.
- R10: Any pulse with `a0`=0 stops status tracking at its chip-select fall. A `statusIn` change made after the first read pulse does not appear in the bits read afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Host chip select, active low, asynchronous |
| a0 | input | 1 | Host address strobe, sampled at chip-select fall |
| rdWrN | input | 1 | Host direction, 1 = read, sampled at chip-select fall |
| d0In | input | 1 | Host data pin, input side |
| d0Out | output | 1 | Host data pin, output value |
| d0Oe | output | 1 | Host data pin, output enable |
| statusIn | input | 12 | Live status word from the rest of the chip |
| ctrlReg | output | 47 | Committed control word, pixel clock domain |

## Verification
Two situations are hard to reach from the ports. The first is status tracking being stopped mid-read, because the status image is overwritten every cycle until some pulse freezes it. The bench starts a readback, changes `statusIn` after the first read pulse, and shows that the remaining 11 status bits still hold the old word. The second is a strobe changed while chip select is low: the bench opens a write pulse, raises `a0` in the low phase, and confirms that no commit follows. Commit latency is probed cycle by cycle around the chip-select rise, and a double readback shows the ring realigns after 59 rotations.

// File: rtl/srp_pkg.sv
package srp_pkg;

  // Operation chosen by a0 / rdWrN at the chip-select fall
  typedef enum logic [1:0] {
    OP_SHIFT  = 2'b00,  // a0=0 rdWrN=0
    OP_READ   = 2'b01,  // a0=0 rdWrN=1
    OP_COMMIT = 2'b10,  // a0=1 rdWrN=0
    OP_STATUS = 2'b11   // a0=1 rdWrN=1
  } srpOp_t;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic rotate;
    logic loadCtrl;
    logic grabStatus;
    logic stopStatus;
    logic dBit;
  } srpStrobe_t;

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int WIDTH   = 1,
  parameter int STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= RST_VAL;
    else       stg[0] <= asyncIn;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[i] <= RST_VAL;
      else       stg[i] <= stg[i-1];
    end
  end

  assign syncOut = stg[STAGES-1];

endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csRaw,
  input  logic       csS,
  input  logic       a0S,
  input  logic       rwS,
  input  logic       dS,
  output srpStrobe_t strb,
  output logic       oe
);

  logic   csPrev;
  logic   csFall;
  logic   csRise;
  srpOp_t opQ;
  logic   rdActive;

  assign csFall = csPrev & ~csS;
  assign csRise = ~csPrev & csS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      opQ      <= OP_SHIFT;
      rdActive <= 1'b0;
    end else begin
      csPrev <= csS;
      if (csFall) begin
        opQ      <= srpOp_t'({a0S, rwS});
        rdActive <= ~a0S & rwS;
      end else if (csRise) begin
        rdActive <= 1'b0;
      end
    end
  end

  always_comb begin
    strb            = '0;
    strb.dBit       = dS;
    strb.stopStatus = csFall & ~a0S;
    if (csRise) begin
      unique case (opQ)
        OP_SHIFT:  strb.shiftIn    = 1'b1;
        OP_READ:   strb.rotate     = 1'b1;
        OP_COMMIT: strb.loadCtrl   = 1'b1;
        OP_STATUS: strb.grabStatus = 1'b1;
        default:   strb.shiftIn    = 1'b0;
      endcase
    end
  end

  // Raw pin gates the driver so it releases at once when chip select lifts
  assign oe = ~csRaw & rdActive;

endmodule

// File: rtl/srp_data.sv
module srp_data
  import srp_pkg::*;
#(
  parameter int CTRL_W = 47,
  parameter int STAT_W = 12,
  parameter logic [CTRL_W-1:0] CTRL_DEFAULT = '0,
  localparam int IMG_W = CTRL_W + STAT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  srpStrobe_t        strb,
  input  logic [STAT_W-1:0] statusIn,
  output logic [IMG_W-1:0]  image,
  output logic              live,
  output logic [CTRL_W-1:0] ctrlQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      image <= '0;
      live  <= 1'b0;
      ctrlQ <= CTRL_DEFAULT;
    end else begin
      if (strb.grabStatus)      live <= 1'b1;
      else if (strb.stopStatus) live <= 1'b0;

      if (strb.shiftIn)
        image[CTRL_W-1:0] <= {strb.dBit, image[CTRL_W-1:1]};
      else if (strb.rotate)
        image <= {image[IMG_W-2:0], image[IMG_W-1]};
      else if (strb.grabStatus || live)
        image[IMG_W-1:CTRL_W] <= statusIn;

      if (strb.loadCtrl) ctrlQ <= image[CTRL_W-1:0];
    end
  end

endmodule

// File: rtl/srp_top.sv
module srp_top
  import srp_pkg::*;
#(
  parameter int CTRL_W = 47,
  parameter int STAT_W = 12,
  parameter int SYNC_STAGES = 2,
  parameter logic [CTRL_W-1:0] CTRL_DEFAULT = '0,
  localparam int IMG_W = CTRL_W + STAT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              a0,
  input  logic              rdWrN,
  input  logic              d0In,
  output logic              d0Out,
  output logic              d0Oe,
  input  logic [STAT_W-1:0] statusIn,
  output logic [CTRL_W-1:0] ctrlReg
);

  logic [3:0]       pinSync;
  srpStrobe_t       strb;
  logic [IMG_W-1:0] image;
  logic             live;

  srp_sync #(
    .WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)
  ) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({csN, a0, rdWrN, d0In}),
    .syncOut(pinSync)
  );

  srp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .csRaw(csN),
    .csS(pinSync[3]), .a0S(pinSync[2]), .rwS(pinSync[1]), .dS(pinSync[0]),
    .strb(strb),
    .oe(d0Oe)
  );

  srp_data #(
    .CTRL_W(CTRL_W), .STAT_W(STAT_W), .CTRL_DEFAULT(CTRL_DEFAULT)
  ) u_data (
    .clk(clk), .rstN(rstN),
    .strb(strb),
    .statusIn(statusIn),
    .image(image),
    .live(live),
    .ctrlQ(ctrlReg)
  );

  assign d0Out = image[IMG_W-1];

endmodule

// File: rtl/srp_chk.sv
module srp_chk
  import srp_pkg::*;
#(
  parameter int CTRL_W = 47,
  parameter int STAT_W = 12,
  parameter logic [CTRL_W-1:0] CTRL_DEFAULT = '0,
  localparam int IMG_W = CTRL_W + STAT_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              d0Oe,
  input logic [STAT_W-1:0] statusIn,
  input logic [CTRL_W-1:0] ctrlReg,
  input logic [IMG_W-1:0]  image,
  input logic              live,
  input srpStrobe_t        strb
);

  logic rstSeen = 1'b0;
  always_ff @(posedge clk) if (!rstN) rstSeen <= 1'b1;

  always @(posedge clk) begin
    if (!rstN && rstSeen)
      a_r1_reset_state: assert (ctrlReg == CTRL_DEFAULT && !d0Oe);
  end

  a_r2_oe_off: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !d0Oe);

  a_r5_ctrl_only_commit: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadCtrl |=> $stable(ctrlReg));

  a_r3_shift_keeps_status: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftIn |=> $stable(image[IMG_W-1:CTRL_W]));

  a_r6_status_follows: assert property (@(posedge clk) disable iff (!rstN)
    (live || strb.grabStatus) |=> image[IMG_W-1:CTRL_W] == $past(statusIn));

  a_r7_rotate_keeps_bits: assert property (@(posedge clk) disable iff (!rstN)
    strb.rotate |=> $countones(image) == $past($countones(image)));

  a_r9_single_op: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftIn, strb.rotate, strb.loadCtrl, strb.grabStatus, strb.stopStatus}));

endmodule

bind srp_top srp_chk #(
  .CTRL_W(CTRL_W), .STAT_W(STAT_W), .CTRL_DEFAULT(CTRL_DEFAULT)
) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .d0Oe(d0Oe),
  .statusIn(statusIn), .ctrlReg(ctrlReg),
  .image(image), .live(live), .strb(strb)
);

// File: tb/sim_srp_top.sv
module sim_srp_top;

  localparam int CW = 47;
  localparam int SW = 12;
  localparam int IW = CW + SW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csN = 1'b1;
  logic          a0 = 1'b0;
  logic          rdWrN = 1'b0;
  logic          d0In = 1'b0;
  logic          d0Out;
  logic          d0Oe;
  logic [SW-1:0] statusIn = '0;
  logic [CW-1:0] ctrlReg;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  localparam logic [CW-1:0] PAT_A = 47'h2A3C96E10F2D;
  localparam logic [CW-1:0] PAT_B = 47'h15C33E7A81B4;

  srp_top u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .a0(a0), .rdWrN(rdWrN),
    .d0In(d0In), .d0Out(d0Out), .d0Oe(d0Oe),
    .statusIn(statusIn), .ctrlReg(ctrlReg)
  );

  always #5 clk = ~clk;

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One chip-select pulse; flipA0 changes a0 during the low phase
  task automatic pulse(input bit av, input bit rv, input bit dv, input bit flipA0, output bit rdBit);
    @(negedge clk); a0 = av; rdWrN = rv; d0In = dv;
    @(negedge clk); csN = 1'b0;
    if (flipA0) begin @(negedge clk); a0 = ~av; end
    repeat (4) @(negedge clk);
    rdBit = d0Out;
    if (rv && !av) check(d0Oe === 1'b1, "R7 oe during read", {63'd0, d0Oe}, 64'd1);
    csN = 1'b1;
    @(negedge clk);
    check(d0Oe === 1'b0, "R2 oe off with cs high", {63'd0, d0Oe}, 64'd0);
    repeat (4) @(negedge clk);
  endtask

  task automatic writeWord(input logic [CW-1:0] w);
    bit unused;
    for (int i = 0; i < CW; i++) pulse(1'b0, 1'b0, w[i], 1'b0, unused);
  endtask

  task automatic readAll(input logic [SW-1:0] changeTo, input bit doChange, output logic [IW-1:0] got);
    bit b;
    pulse(1'b1, 1'b1, 1'b0, 1'b0, b);
    for (int i = 0; i < IW; i++) begin
      pulse(1'b0, 1'b1, 1'b0, 1'b0, b);
      got[IW-1-i] = b;
      if (i == 0 && doChange) statusIn = changeTo;
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(ctrlReg === '0, "R1 ctrl default in reset", 64'(ctrlReg), 64'd0);
    check(d0Oe === 1'b0, "R1 oe low in reset", {63'd0, d0Oe}, 64'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(ctrlReg === '0, "R1 ctrl default after release", 64'(ctrlReg), 64'd0);
  endtask

  task automatic testWriteCommit();
    writeWord(PAT_A);
    check(ctrlReg === '0, "R5 ctrl unchanged by writes", 64'(ctrlReg), 64'd0);
    // timed commit: csN rises at a negedge, value appears on 3rd posedge
    @(negedge clk); a0 = 1'b1; rdWrN = 1'b0;
    @(negedge clk); csN = 1'b0;
    repeat (4) @(negedge clk);
    csN = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(ctrlReg === '0, "R4 ctrl not yet updated after 2 edges", 64'(ctrlReg), 64'd0);
    @(posedge clk); @(negedge clk);
    check(ctrlReg === PAT_A, "R3 R4 ctrl updated on 3rd edge", 64'(ctrlReg), 64'(PAT_A));
    repeat (4) @(negedge clk);
  endtask

  task automatic testReadback();
    logic [IW-1:0] got;
    statusIn = 12'hA5C;
    readAll('0, 1'b0, got);
    check(got[IW-1:CW] === 12'hA5C, "R6 R7 status read MSB first", 64'(got[IW-1:CW]), 64'hA5C);
    check(got[CW-1:0] === PAT_A, "R7 control read after status", 64'(got[CW-1:0]), 64'(PAT_A));
    check(ctrlReg === PAT_A, "R5 ctrl unchanged by reads", 64'(ctrlReg), 64'(PAT_A));
    statusIn = 12'h3E1;
    readAll('0, 1'b0, got);
    check(got[IW-1:CW] === 12'h3E1, "R6 status reloaded on second read", 64'(got[IW-1:CW]), 64'h3E1);
    check(got[CW-1:0] === PAT_A, "R8 second readback realigned", 64'(got[CW-1:0]), 64'(PAT_A));
  endtask

  task automatic testCommitAfterRead();
    bit b;
    pulse(1'b1, 1'b0, 1'b0, 1'b0, b);
    check(ctrlReg === PAT_A, "R8 commit after full read keeps ctrl", 64'(ctrlReg), 64'(PAT_A));
  endtask

  task automatic testFreeze();
    logic [IW-1:0] got;
    statusIn = 12'h9D2;
    readAll(12'h62D, 1'b1, got);
    check(got[IW-1:CW] === 12'h9D2, "R10 status frozen during read", 64'(got[IW-1:CW]), 64'h9D2);
  endtask

  task automatic testLateStrobe();
    bit b;
    // a0 flips to 1 while cs low: must still act as a write, not a commit
    pulse(1'b0, 1'b0, 1'b1, 1'b1, b);
    check(ctrlReg === PAT_A, "R9 late a0 change ignored", 64'(ctrlReg), 64'(PAT_A));
    writeWord(PAT_B);
    pulse(1'b1, 1'b0, 1'b0, 1'b0, b);
    check(ctrlReg === PAT_B, "R3 second pattern committed", 64'(ctrlReg), 64'(PAT_B));
  endtask

  initial begin
    testReset();
    testWriteCommit();
    testReadback();
    testCommitAfterRead();
    testFreeze();
    testLateStrobe();
    finishRun();
  end

endmodule